// File: doc/BRIEF.md
# SMBus Host Register Block

This block is the register front end of an SMBus host controller. A byte-wide host port reads and writes eight registers: status, control, command, target address, two data bytes, a block-data byte and an auxiliary-control byte. When software sets the start bit, the block decodes the protocol field and the read flag into one bus operation. It then hands that operation to a separate bus engine over a request/done handshake, along with the 7-bit target, the command byte and a 16-bit write payload.

The bus engine reports completion with a done pulse, an ack/nack flag and up to 16 bits of returned data. The block places that data into the data registers and updates status. Software can abort an operation with the kill bit. Software can also choose a deferred start: with interrupts disabled, the transaction waits until the next status read. An interrupt line reflects status whenever interrupts are enabled.

Top module: `smb_host_regs`

## Requirements
- R1: Registers sit at offsets status 0x0, control 0x2, command 0x3, target address 0x4, data-low 0x5, data-high 0x6, block data 0x7 and auxiliary 0xD. Command, address, both data registers and block data read back what was written. The auxiliary register keeps only bits 1:0. A control read returns only bits 4:0, so start (bit 6) always reads 0. Any other offset reads 0x00 and ignores writes.
- R2: A status write clears each status bit written as 1, except host busy (bit 0), which a status write never clears.
- R3: Control bits 4:2 select the protocol, and the address read flag refines it. The operation codes on `bus_op` are:
  - protocol 0 gives 0 (quick);
  - protocol 1 gives 1 (send) or 2 (receive);
  - protocol 2 gives 3 or 4 (byte data write/read);
  - protocol 3 gives 5 or 6 (word write/read);
  - protocol 5 gives 7 or 8 (block write/read);
  - protocol 6 gives 9 (I2C block read).
  
  Protocols 4 and 7 issue no request and set device error (status bit 2).
- R4: Address register bit 0 is the read flag and bits 7:1 appear on `bus_target`. The command register appears on `bus_cmd`. For codes 0 to 8, `bus_wdata` is {data-high, data-low}.
- R5: If device error is already set when a transaction would launch, no request is issued and device error stays set.
- R6: A word read puts returned bits 15:8 in data-high and bits 7:0 in data-low. Byte-data reads and receives put bits 7:0 in data-low and leave data-high unchanged.
- R7: A done pulse with ack sets interrupt (status bit 1). A done pulse with nack sets device error instead. A block read also loads data-low with returned bits 15:8 (the count) and block data with bits 7:0. Block read and I2C block read also set byte done (status bit 7).
- R8: Start written with interrupt enable (control bit 0) clear only sets busy and arms a pending start. The next status read returns the status including busy, then clears busy and launches the transaction.
- R9: Writing control with kill (bit 1) set drops any request or pending start, clears busy and sets failed (status bit 4). A later done pulse changes nothing.
- R10: `irq` is high exactly when interrupt enable is set and any status bit other than busy is set.
- R11: Code 9 drives `bus_read` high whatever the read flag, and sends data-high as the offset in `bus_wdata[7:0]` with bits 15:8 zero. A done pulse with ack loads block data from returned bits 7:0.
- R12: Reset clears status and all pending or in-flight state. An immediate start sets busy and holds `bus_req` with stable fields until done. Start writes while a request is in flight or pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (side effects on status read) |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| bus_req | output | 1 | Operation request to bus engine, held until done |
| bus_op | output | 4 | Operation code |
| bus_target | output | 7 | 7-bit target address |
| bus_read | output | 1 | Read direction |
| bus_cmd | output | 8 | Command byte |
| bus_wdata | output | 16 | Write payload |
| bus_done | input | 1 | Completion pulse from bus engine |
| bus_nack | input | 1 | Completion failed |
| bus_rdata | input | 16 | Returned data |

## Verification
The launcher is tried with every protocol code in both directions. Word and byte traffic use distinct high and low bytes, so a swap of data-high and data-low or a stray write into data-high is visible. An I2C block read with the read flag clear separates the forced read and the offset from a plain read. Immediate and deferred starts are run back to back. These runs tell apart a launch on the control write from a launch on the status read. Nack, a preset device error, invalid protocols, kill followed by a late done, and status writes during busy show which path updates status.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 2 * BYTE_W;
    localparam int unsigned TGT_W  = BYTE_W - 1;

    // register offsets
    localparam int unsigned OFF_STS = 'h0;
    localparam int unsigned OFF_CTL = 'h2;
    localparam int unsigned OFF_CMD = 'h3;
    localparam int unsigned OFF_ADR = 'h4;
    localparam int unsigned OFF_DLO = 'h5;
    localparam int unsigned OFF_DHI = 'h6;
    localparam int unsigned OFF_BLK = 'h7;
    localparam int unsigned OFF_AUX = 'hD;

    // status bit positions
    localparam int unsigned ST_BUSY  = 0;
    localparam int unsigned ST_INTR  = 1;
    localparam int unsigned ST_DERR  = 2;
    localparam int unsigned ST_FAIL  = 4;
    localparam int unsigned ST_BDONE = 7;

    // control bit positions
    localparam int unsigned CT_IEN   = 0;
    localparam int unsigned CT_KILL  = 1;
    localparam int unsigned CT_START = 6;

    typedef enum logic [3:0] {
        OP_QUICK    = 4'd0,
        OP_SEND     = 4'd1,
        OP_RECV     = 4'd2,
        OP_WR_BYTE  = 4'd3,
        OP_RD_BYTE  = 4'd4,
        OP_WR_WORD  = 4'd5,
        OP_RD_WORD  = 4'd6,
        OP_BLK_WR   = 4'd7,
        OP_BLK_RD   = 4'd8,
        OP_I2C_BRD  = 4'd9
    } bus_op_e;

    typedef struct packed {
        bus_op_e             op;
        logic [TGT_W-1:0]    tgt;
        logic                rd;
        logic [BYTE_W-1:0]   cmd;
        logic [WORD_W-1:0]   wdata;
    } bus_req_t;

    function automatic logic [BYTE_W-1:0] w1c(input logic [BYTE_W-1:0] cur,
                                              input logic [BYTE_W-1:0] wv);
        logic [BYTE_W-1:0] keep_busy;
        keep_busy = '0;
        keep_busy[ST_BUSY] = 1'b1;
        return cur & ~(wv & ~keep_busy);
    endfunction

endpackage

// File: rtl/smb_proto_decode.sv
module smb_proto_decode
    import smb_host_pkg::*;
(
    input  logic [2:0] proto,
    input  logic       rd_flag,
    output bus_op_e    op,
    output logic       valid
);
    always_comb begin
        valid = 1'b1;
        op    = OP_QUICK;
        case (proto)
            3'd0: op = OP_QUICK;
            3'd1: op = rd_flag ? OP_RECV    : OP_SEND;
            3'd2: op = rd_flag ? OP_RD_BYTE : OP_WR_BYTE;
            3'd3: op = rd_flag ? OP_RD_WORD : OP_WR_WORD;
            3'd5: op = rd_flag ? OP_BLK_RD  : OP_BLK_WR;
            3'd6: op = OP_I2C_BRD;
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/smb_irq_gen.sv
module smb_irq_gen
    import smb_host_pkg::*;
(
    input  logic              ien,
    input  logic [BYTE_W-1:0] stat,
    output logic              irq
);
    logic [BYTE_W-1:0] flag_mask;
    always_comb begin
        flag_mask = '1;
        flag_mask[ST_BUSY] = 1'b0;
        irq = ien && ((stat & flag_mask) != '0);
    end
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic              bus_req,
    output logic [3:0]        bus_op,
    output logic [6:0]        bus_target,
    output logic              bus_read,
    output logic [7:0]        bus_cmd,
    output logic [15:0]       bus_wdata,
    input  logic              bus_done,
    input  logic              bus_nack,
    input  logic [15:0]       bus_rdata
);
    localparam logic [BYTE_W-1:0] CTL_STORE_MASK = ~(BYTE_W'(1) << CT_START);
    localparam logic [BYTE_W-1:0] CTL_READ_MASK  = BYTE_W'(8'h1F);
    localparam logic [BYTE_W-1:0] AUX_MASK       = BYTE_W'(8'h03);

    logic [BYTE_W-1:0] stat_q, ctl_q, cmd_q, sadr_q, dlo_q, dhi_q, blk_q, aux_q;
    logic [BYTE_W-1:0] stat_n, dlo_n, dhi_n, blk_n;
    logic              pend_q, pend_n, infl_q, infl_n;
    bus_req_t          req_q, req_n;

    logic wr_sts, wr_ctl, rd_sts, start_wr, kill_wr, idle, defer_go, launch;
    logic [2:0] dec_proto;
    bus_op_e    dec_op;
    logic       dec_ok;

    always_comb begin
        wr_sts   = reg_wr && (reg_addr == ADDR_W'(OFF_STS));
        wr_ctl   = reg_wr && (reg_addr == ADDR_W'(OFF_CTL));
        rd_sts   = reg_rd && (reg_addr == ADDR_W'(OFF_STS));
        start_wr = wr_ctl && reg_wdata[CT_START];
        kill_wr  = wr_ctl && reg_wdata[CT_KILL];
        idle     = !pend_q && !infl_q;
        defer_go = rd_sts && pend_q;
        launch   = defer_go || (start_wr && idle && reg_wdata[CT_IEN]);
        dec_proto = defer_go ? ctl_q[4:2] : reg_wdata[4:2];
    end

    smb_proto_decode u_dec (
        .proto   (dec_proto),
        .rd_flag (sadr_q[0]),
        .op      (dec_op),
        .valid   (dec_ok)
    );

    smb_irq_gen u_irq (
        .ien  (ctl_q[CT_IEN]),
        .stat (stat_q),
        .irq  (irq)
    );

    always_comb begin
        stat_n = stat_q;
        pend_n = pend_q;
        infl_n = infl_q;
        req_n  = req_q;
        dlo_n  = dlo_q;
        dhi_n  = dhi_q;
        blk_n  = blk_q;

        if (reg_wr && reg_addr == ADDR_W'(OFF_DLO)) dlo_n = reg_wdata;
        if (reg_wr && reg_addr == ADDR_W'(OFF_DHI)) dhi_n = reg_wdata;
        if (reg_wr && reg_addr == ADDR_W'(OFF_BLK)) blk_n = reg_wdata;
        if (wr_sts) stat_n = w1c(stat_q, reg_wdata);

        // completion from the bus engine
        if (bus_done && infl_q) begin
            infl_n = 1'b0;
            stat_n[ST_BUSY] = 1'b0;
            if (bus_nack) begin
                stat_n[ST_DERR] = 1'b1;
            end else begin
                stat_n[ST_INTR] = 1'b1;
                case (req_q.op)
                    OP_RECV, OP_RD_BYTE: dlo_n = bus_rdata[BYTE_W-1:0];
                    OP_RD_WORD: begin
                        dlo_n = bus_rdata[BYTE_W-1:0];
                        dhi_n = bus_rdata[WORD_W-1:BYTE_W];
                    end
                    OP_BLK_RD: begin
                        dlo_n = bus_rdata[WORD_W-1:BYTE_W];
                        blk_n = bus_rdata[BYTE_W-1:0];
                        stat_n[ST_BDONE] = 1'b1;
                    end
                    OP_I2C_BRD: begin
                        blk_n = bus_rdata[BYTE_W-1:0];
                        stat_n[ST_BDONE] = 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        // start with interrupts off: park until status read
        if (start_wr && idle && !reg_wdata[CT_IEN]) begin
            stat_n[ST_BUSY] = 1'b1;
            pend_n = 1'b1;
        end

        if (launch) begin
            if (defer_go) begin
                stat_n[ST_BUSY] = 1'b0;
                pend_n = 1'b0;
            end
            if (stat_q[ST_DERR]) begin
                stat_n[ST_DERR] = 1'b1;
            end else if (!dec_ok) begin
                stat_n[ST_DERR] = 1'b1;
            end else begin
                infl_n    = 1'b1;
                req_n.op  = dec_op;
                req_n.tgt = sadr_q[BYTE_W-1:1];
                req_n.cmd = cmd_q;
                if (dec_op == OP_I2C_BRD) begin
                    req_n.rd    = 1'b1;
                    req_n.wdata = {{BYTE_W{1'b0}}, dhi_q};
                end else begin
                    req_n.rd    = sadr_q[0];
                    req_n.wdata = {dhi_q, dlo_q};
                end
                if (!defer_go) stat_n[ST_BUSY] = 1'b1;
            end
        end

        if (kill_wr) begin
            stat_n[ST_BUSY] = 1'b0;
            stat_n[ST_FAIL] = 1'b1;
            infl_n = 1'b0;
            pend_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            ctl_q  <= '0;
            cmd_q  <= '0;
            sadr_q <= '0;
            dlo_q  <= '0;
            dhi_q  <= '0;
            blk_q  <= '0;
            aux_q  <= '0;
            pend_q <= 1'b0;
            infl_q <= 1'b0;
            req_q  <= '0;
        end else begin
            stat_q <= stat_n;
            pend_q <= pend_n;
            infl_q <= infl_n;
            req_q  <= req_n;
            dlo_q  <= dlo_n;
            dhi_q  <= dhi_n;
            blk_q  <= blk_n;
            if (wr_ctl) ctl_q <= reg_wdata & CTL_STORE_MASK;
            if (reg_wr && reg_addr == ADDR_W'(OFF_CMD)) cmd_q  <= reg_wdata;
            if (reg_wr && reg_addr == ADDR_W'(OFF_ADR)) sadr_q <= reg_wdata;
            if (reg_wr && reg_addr == ADDR_W'(OFF_AUX)) aux_q  <= reg_wdata & AUX_MASK;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if      (reg_addr == ADDR_W'(OFF_STS)) reg_rdata = stat_q;
        else if (reg_addr == ADDR_W'(OFF_CTL)) reg_rdata = ctl_q & CTL_READ_MASK;
        else if (reg_addr == ADDR_W'(OFF_CMD)) reg_rdata = cmd_q;
        else if (reg_addr == ADDR_W'(OFF_ADR)) reg_rdata = sadr_q;
        else if (reg_addr == ADDR_W'(OFF_DLO)) reg_rdata = dlo_q;
        else if (reg_addr == ADDR_W'(OFF_DHI)) reg_rdata = dhi_q;
        else if (reg_addr == ADDR_W'(OFF_BLK)) reg_rdata = blk_q;
        else if (reg_addr == ADDR_W'(OFF_AUX)) reg_rdata = aux_q;
    end

    assign bus_req    = infl_q;
    assign bus_op     = req_q.op;
    assign bus_target = req_q.tgt;
    assign bus_read   = req_q.rd;
    assign bus_cmd    = req_q.cmd;
    assign bus_wdata  = req_q.wdata;

endmodule

// File: rtl/smb_host_checker.sv
module smb_host_checker #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              bus_req,
    input logic [3:0]        bus_op,
    input logic              bus_done,
    input logic              bus_nack,
    input logic [7:0]        stat,
    input logic              ien,
    input logic              irq
);
    logic kill_now, sts_wr_now;
    assign kill_now   = reg_wr && reg_addr == ADDR_W'(2) && reg_wdata[1];
    assign sts_wr_now = reg_wr && reg_addr == ADDR_W'(0);

    // R12: a request only appears after a host access
    p_launch_by_host_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(reg_wr || reg_rd));

    // R12: request held with stable operation until done or kill
    p_req_held_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_done && !kill_now) |=> (bus_req && $stable(bus_op)));

    // R9: kill drops the request, sets failed and clears busy
    p_kill_effect_r9: assert property (@(posedge clk) disable iff (rst)
        kill_now |=> (!bus_req && stat[4] && !stat[0]));

    // R2: status write never clears busy
    p_busy_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (sts_wr_now && stat[0] && !bus_done) |=> stat[0]);

    // R7: nack on completion raises device error
    p_nack_derr_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_done && bus_nack) |=> stat[2]);

    // R10: no interrupt while interrupts are disabled
    p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
        !ien |-> !irq);
endmodule

bind smb_host_regs smb_host_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .bus_req   (bus_req),
    .bus_op    (bus_op),
    .bus_done  (bus_done),
    .bus_nack  (bus_nack),
    .stat      (stat_q),
    .ien       (ctl_q[0]),
    .irq       (irq)
);

// File: tb/smb_host_regs_bench.sv
module smb_host_regs_bench;
    localparam int unsigned AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          irq, bus_req, bus_read;
    logic [3:0]    bus_op;
    logic [6:0]    bus_target;
    logic [7:0]    bus_cmd;
    logic [15:0]   bus_wdata;
    logic          bus_done = 1'b0, bus_nack = 1'b0;
    logic [15:0]   bus_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #5 clk = ~clk;

    smb_host_regs #(.ADDR_W(AW)) u_smb_host_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .bus_req(bus_req), .bus_op(bus_op), .bus_target(bus_target),
        .bus_read(bus_read), .bus_cmd(bus_cmd), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_nack(bus_nack), .bus_rdata(bus_rdata)
    );

    // monitor: compare read data against the scoreboard queue
    initial forever begin
        @(negedge clk);
        #2;
        if (reg_rd && q_exp.size() > 0) begin
            logic [7:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (reg_rdata !== e) begin
                errors++;
                $display("FAIL %s: read %02h expected %02h", t, reg_rdata, e);
            end
        end
    end

    task automatic wr(input int unsigned a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int unsigned a, input logic [7:0] e, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = AW'(a);
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %04h expected %04h", tag, act, exp);
        end
    endtask

    task automatic respond(input logic nk, input logic [15:0] d);
        @(negedge clk);
        bus_done = 1'b1; bus_nack = nk; bus_rdata = d;
        @(negedge clk);
        bus_done = 1'b0; bus_nack = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        rd(0, 8'h00, "R12 reset status");
        chk("R12 reset bus_req", 16'(bus_req), 16'h0);
        chk("R10 reset irq", 16'(irq), 16'h0);

        // R1 register map
        wr(3, 8'h5A); rd(3, 8'h5A, "R1 command");
        wr(7, 8'hC3); rd(7, 8'hC3, "R1 block data");
        wr(13, 8'hFF); rd(13, 8'h03, "R1 aux mask");
        wr(2, 8'h9D); rd(2, 8'h1D, "R1 control mask");
        chk("R1 no launch without start", 16'(bus_req), 16'h0);
        wr(1, 8'hFF); rd(1, 8'h00, "R1 unused offset");
        rd(15, 8'h00, "R1 unused offset 0xF");
        wr(2, 8'h00);

        // R3 R4 R6 word write
        wr(4, 8'hA4); wr(3, 8'h10); wr(5, 8'h34); wr(6, 8'h12);
        wr(2, 8'h4D);
        chk("R12 word write req", 16'(bus_req), 16'h1);
        chk("R3 word write op", 16'(bus_op), 16'd5);
        chk("R4 target", 16'(bus_target), 16'h52);
        chk("R4 read flag", 16'(bus_read), 16'h0);
        chk("R4 cmd", 16'(bus_cmd), 16'h10);
        chk("R4 wdata", bus_wdata, 16'h1234);
        rd(0, 8'h01, "R12 busy during flight");
        wr(2, 8'h41);
        chk("R12 start ignored in flight", 16'(bus_op), 16'd5);
        respond(1'b0, 16'h0000);
        rd(0, 8'h02, "R7 intr on ack");
        chk("R10 irq with intr", 16'(irq), 16'h1);
        wr(0, 8'hFF);
        rd(0, 8'h00, "R2 w1c clears");
        chk("R10 irq cleared", 16'(irq), 16'h0);

        // R6 word read
        wr(4, 8'hA5); wr(2, 8'h4D);
        chk("R3 word read op", 16'(bus_op), 16'd6);
        chk("R4 read flag set", 16'(bus_read), 16'h1);
        respond(1'b0, 16'hBEEF);
        rd(5, 8'hEF, "R6 word low");
        rd(6, 8'hBE, "R6 word high");
        wr(0, 8'hFF);

        // R6 byte read keeps data-high
        wr(2, 8'h49);
        chk("R3 byte read op", 16'(bus_op), 16'd4);
        respond(1'b0, 16'h9977);
        rd(5, 8'h77, "R6 byte read low");
        rd(6, 8'hBE, "R6 byte read high untouched");
        wr(0, 8'hFF);

        // R7 nack
        wr(4, 8'hA4); wr(2, 8'h41);
        chk("R3 quick op", 16'(bus_op), 16'd0);
        respond(1'b1, 16'h0000);
        rd(0, 8'h04, "R7 nack sets device error");

        // R5 preset device error blocks launch
        wr(2, 8'h4D);
        chk("R5 no request", 16'(bus_req), 16'h0);
        rd(0, 8'h04, "R5 status unchanged");
        wr(0, 8'h04);

        // R3 invalid protocols
        wr(2, 8'h51);
        chk("R3 proto 4 no request", 16'(bus_req), 16'h0);
        rd(0, 8'h04, "R3 proto 4 device error");
        wr(0, 8'h04);
        wr(2, 8'h5D);
        chk("R3 proto 7 no request", 16'(bus_req), 16'h0);
        rd(0, 8'h04, "R3 proto 7 device error");
        wr(0, 8'h04);

        // R11 I2C block read with read flag clear
        wr(6, 8'h20); wr(2, 8'h59);
        chk("R11 op", 16'(bus_op), 16'd9);
        chk("R11 forced read", 16'(bus_read), 16'h1);
        chk("R11 offset payload", bus_wdata, 16'h0020);
        respond(1'b0, 16'h1155);
        rd(7, 8'h55, "R11 block data");
        rd(0, 8'h82, "R7 byte done and intr");
        wr(0, 8'hFF);

        // R7 block read
        wr(4, 8'hA5); wr(2, 8'h55);
        chk("R3 block read op", 16'(bus_op), 16'd8);
        respond(1'b0, 16'h0304);
        rd(5, 8'h03, "R7 block count");
        rd(7, 8'h04, "R7 block first byte");
        wr(0, 8'hFF);

        // R8 deferred start
        wr(4, 8'hA4); wr(2, 8'h44);
        chk("R8 no request before read", 16'(bus_req), 16'h0);
        rd(0, 8'h01, "R8 busy returned");
        chk("R8 launched on read", 16'(bus_req), 16'h1);
        chk("R8 send op", 16'(bus_op), 16'd1);
        rd(0, 8'h00, "R8 busy cleared");
        respond(1'b0, 16'h0000);
        rd(0, 8'h02, "R8 completion");
        chk("R10 irq off when disabled", 16'(irq), 16'h0);
        wr(0, 8'hFF);

        // R9 kill
        wr(2, 8'h4D);
        chk("R9 request before kill", 16'(bus_req), 16'h1);
        wr(2, 8'h02);
        chk("R9 request dropped", 16'(bus_req), 16'h0);
        rd(0, 8'h10, "R9 failed set");
        respond(1'b0, 16'hFFFF);
        rd(0, 8'h10, "R9 late done ignored");
        wr(0, 8'hFF);

        // R2 busy not cleared by status write
        wr(2, 8'h4D);
        wr(0, 8'hFF);
        rd(0, 8'h01, "R2 busy survives w1c");
        respond(1'b0, 16'h0000);
        rd(0, 8'h02, "R2 busy cleared by done");

        repeat (4) @(negedge clk);
        summary();
    end
endmodule